// File: doc/BRIEF.md
# Posted-write peripheral bus bridge

This bridge links a fast CPU load/store port to a slow peripheral bus that advances only on a clock-enable strobe, one strobe every `DIV` CPU cycles (four by default). Both sides share one clock domain. The strobe runs freely from reset. Its rate depends only on `DIV`, so running the CPU clock faster does not change how many CPU cycles a bus transfer takes.

A store goes into a one-entry posted-write buffer and releases the CPU in the same cycle. While the buffer drains, the CPU may run anything that does not need the bus. A second store, a load or a barrier waits until the buffer is empty. A load is never buffered: it holds the CPU stalled for the whole setup/access round trip. Its data comes back in the single cycle in which the stall drops.

The peripheral side runs a two-phase sequence: a setup phase, then an access phase. The access phase lasts until a strobe arrives with ready asserted.

Top module: `pbus_bridge`

## Requirements
- R1: `pclk_en_o` is high for exactly one cycle in every `DIV` cycles. With the default `DIV` = 4, consecutive strobes are exactly 4 cycles apart.
- R2: The CPU request encoding on `cpu_op_i` is 2'b00 load, 2'b01 store, and `cpu_op_i[1]`=1 barrier. A request is accepted in the cycle where `cpu_req_i`=1 and `cpu_stall_o`=0. A store issued while the write buffer is empty is accepted in its first cycle.
- R3: A store issued while a write is buffered stalls. Without wait states, it is accepted in the cycle after the third strobe that follows the earlier store's acceptance cycle.
- R4: A load stalls until the read completes. `cpu_rvalid_o` is high and `cpu_rdata_o` holds the peripheral data only in the single cycle where the load is accepted. That cycle is the one after the strobe that ends the access phase, which is 3 strobes after issue on an idle bus with no wait states.
- R5: A load issued while a write is buffered starts only after that write completes (6 strobes in all without wait states). It returns the value the write stored.
- R6: A barrier stalls while a write is buffered and is released in the cycle after the write's final strobe. A barrier issued with an empty buffer is accepted in its first cycle.
- R7: When `cpu_req_i`=0, `cpu_stall_o` is low, even while a buffered write is still on the bus.
- R8: Each transfer spends exactly one strobe period in setup (`psel_o`=1, `penable_o`=0). It then enters access (`penable_o`=1) and stays there until a strobe with `pready_i`=1. Address, direction and write data hold for the whole transfer.
- R9: After reset, `cpu_stall_o`, `cpu_rvalid_o` and `psel_o` are low and the write buffer is empty.
- R10: Each access-phase strobe seen with `pready_i`=0 extends the transfer by one strobe period. A load with W such strobes completes 3+W strobes after issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_req_i | input | 1 | CPU request valid, held while stalled |
| cpu_op_i | input | 2 | 00 load, 01 store, 1x barrier |
| cpu_addr_i | input | AW | Request address |
| cpu_wdata_i | input | DW | Store data |
| cpu_stall_o | output | 1 | CPU must hold its request |
| cpu_rvalid_o | output | 1 | Load data valid (acceptance cycle of a load) |
| cpu_rdata_o | output | DW | Load data |
| pclk_en_o | output | 1 | Peripheral bus clock-enable strobe |
| psel_o | output | 1 | Peripheral select |
| penable_o | output | 1 | Access phase |
| pwrite_o | output | 1 | Transfer is a write |
| paddr_o | output | AW | Peripheral address |
| pwdata_o | output | DW | Peripheral write data |
| prdata_i | input | DW | Peripheral read data |
| pready_i | input | 1 | Peripheral ready, sampled on strobes in access |

## Verification
Every result here is tied to strobe counts, not to fixed cycle counts:
- A store's release falls in its issue cycle.
- A stalled store, a barrier or a load is released in the cycle after the strobe that ends the relevant transfer.
- That strobe is the third after the start point, plus one for each wait state, plus three more if a write was ahead.

The bench samples the stall, the strobe and the read data at each falling edge. It counts the strobes seen from the issue cycle up to the release cycle, and compares the count and the data in that release cycle with values computed from the requirements. Randomized traffic adds checks that load data follows program order against a shadow memory, and that the model peripheral ends up holding every stored value.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
  localparam logic [1:0] OP_LOAD  = 2'b00;
  localparam logic [1:0] OP_STORE = 2'b01;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_SETUP  = 2'd1,
    SQ_ACCESS = 2'd2
  } seq_state_e;
endpackage

// File: rtl/pbus_clkdiv.sv
module pbus_clkdiv #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic pce_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign pce_o = (cnt_q == LAST);
endmodule

// File: rtl/pbus_wbuf.sv
module pbus_wbuf #(
  parameter int AW = 12,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic          valid_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o
);
  logic          valid_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      if (push_i) begin
        valid_q <= 1'b1;
        addr_q  <= addr_i;
        data_q  <= data_i;
      end else if (pop_i) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign valid_o = valid_q;
  assign addr_o  = addr_q;
  assign data_o  = data_q;
endmodule

// File: rtl/pbus_seq.sv
module pbus_seq
  import pbus_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pce_i,
  input  logic          wr_pend_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_pend_i,
  input  logic [AW-1:0] rd_addr_i,
  input  logic          pready_i,
  input  logic [DW-1:0] prdata_i,
  output logic          psel_o,
  output logic          penable_o,
  output logic          pwrite_o,
  output logic [AW-1:0] paddr_o,
  output logic [DW-1:0] pwdata_o,
  output logic          wr_done_o,
  output logic          rd_done_o,
  output logic [DW-1:0] rdata_o
);
  seq_state_e    state_q;
  logic          write_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic [DW-1:0] rdata_q;
  logic          done;

  assign done = pce_i && (state_q == SQ_ACCESS) && pready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SQ_IDLE;
      write_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else if (pce_i) begin
      unique case (state_q)
        SQ_IDLE: begin
          // buffered write first keeps loads in program order
          if (wr_pend_i) begin
            state_q <= SQ_SETUP;
            write_q <= 1'b1;
            addr_q  <= wr_addr_i;
            wdata_q <= wr_data_i;
          end else if (rd_pend_i) begin
            state_q <= SQ_SETUP;
            write_q <= 1'b0;
            addr_q  <= rd_addr_i;
          end
        end
        SQ_SETUP: state_q <= SQ_ACCESS;
        SQ_ACCESS: begin
          if (pready_i) begin
            state_q <= SQ_IDLE;
            if (!write_q) rdata_q <= prdata_i;
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign psel_o    = (state_q != SQ_IDLE);
  assign penable_o = (state_q == SQ_ACCESS);
  assign pwrite_o  = write_q;
  assign paddr_o   = addr_q;
  assign pwdata_o  = wdata_q;
  assign wr_done_o = done && write_q;
  assign rd_done_o = done && !write_q;
  assign rdata_o   = rdata_q;
endmodule

// File: rtl/pbus_bridge.sv
module pbus_bridge
  import pbus_pkg::*;
#(
  parameter int AW  = 12,
  parameter int DW  = 32,
  parameter int DIV = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cpu_req_i,
  input  logic [1:0]    cpu_op_i,
  input  logic [AW-1:0] cpu_addr_i,
  input  logic [DW-1:0] cpu_wdata_i,
  output logic          cpu_stall_o,
  output logic          cpu_rvalid_o,
  output logic [DW-1:0] cpu_rdata_o,
  output logic          pclk_en_o,
  output logic          psel_o,
  output logic          penable_o,
  output logic          pwrite_o,
  output logic [AW-1:0] paddr_o,
  output logic [DW-1:0] pwdata_o,
  input  logic [DW-1:0] prdata_i,
  input  logic          pready_i
);
  logic          pce;
  logic          is_load, is_store, is_bar;
  logic          wbuf_valid;
  logic [AW-1:0] wbuf_addr;
  logic [DW-1:0] wbuf_data;
  logic          st_acc, rd_pend;
  logic          wr_done, rd_done;
  logic          rd_ret_q;

  assign is_load  = cpu_req_i && (cpu_op_i == OP_LOAD);
  assign is_store = cpu_req_i && (cpu_op_i == OP_STORE);
  assign is_bar   = cpu_req_i && cpu_op_i[1];

  assign st_acc  = is_store && !wbuf_valid;
  assign rd_pend = is_load && !rd_ret_q;

  pbus_clkdiv #(.DIV(DIV)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pce_o  (pce)
  );

  pbus_wbuf #(.AW(AW), .DW(DW)) u_wbuf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (st_acc),
    .addr_i  (cpu_addr_i),
    .data_i  (cpu_wdata_i),
    .pop_i   (wr_done),
    .valid_o (wbuf_valid),
    .addr_o  (wbuf_addr),
    .data_o  (wbuf_data)
  );

  pbus_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pce_i     (pce),
    .wr_pend_i (wbuf_valid),
    .wr_addr_i (wbuf_addr),
    .wr_data_i (wbuf_data),
    .rd_pend_i (rd_pend),
    .rd_addr_i (cpu_addr_i),
    .pready_i  (pready_i),
    .prdata_i  (prdata_i),
    .psel_o    (psel_o),
    .penable_o (penable_o),
    .pwrite_o  (pwrite_o),
    .paddr_o   (paddr_o),
    .pwdata_o  (pwdata_o),
    .wr_done_o (wr_done),
    .rd_done_o (rd_done),
    .rdata_o   (cpu_rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_ret_q <= 1'b0;
    else         rd_ret_q <= rd_done;
  end

  assign cpu_rvalid_o = rd_ret_q;
  assign cpu_stall_o  = (is_store && wbuf_valid) ||
                        (is_load && !rd_ret_q) ||
                        (is_bar && wbuf_valid);
  assign pclk_en_o    = pce;
endmodule

// File: rtl/pbus_bridge_chk.sv
module pbus_bridge_chk #(
  parameter int AW = 12
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cpu_req_i,
  input logic [1:0]    cpu_op_i,
  input logic          cpu_stall_o,
  input logic          cpu_rvalid_o,
  input logic          pclk_en_o,
  input logic          psel_o,
  input logic          penable_o,
  input logic          pwrite_o,
  input logic [AW-1:0] paddr_o,
  input logic          pready_i,
  input logic          wbuf_valid
);
  AST_STROBE_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pclk_en_o |=> !pclk_en_o); // R1

  AST_IDLE_NO_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_req_i |-> !cpu_stall_o); // R7

  AST_RVALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_rvalid_o |=> !cpu_rvalid_o); // R4

  AST_BAR_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_req_i && cpu_op_i[1] && !cpu_stall_o) |-> !(psel_o && pwrite_o)); // R6

  AST_ENABLE_NEEDS_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    penable_o |-> psel_o); // R8

  AST_SETUP_ONE_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psel_o && !penable_o && pclk_en_o) |=> (psel_o && penable_o)); // R8

  AST_ACCESS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psel_o && penable_o && !(pclk_en_o && pready_i)) |=>
      (psel_o && penable_o && $stable(paddr_o) && $stable(pwrite_o))); // R10

  AST_WRITE_HAS_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psel_o && pwrite_o) |-> wbuf_valid); // R3
endmodule

bind pbus_bridge pbus_bridge_chk #(.AW(AW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cpu_req_i    (cpu_req_i),
  .cpu_op_i     (cpu_op_i),
  .cpu_stall_o  (cpu_stall_o),
  .cpu_rvalid_o (cpu_rvalid_o),
  .pclk_en_o    (pclk_en_o),
  .psel_o       (psel_o),
  .penable_o    (penable_o),
  .pwrite_o     (pwrite_o),
  .paddr_o      (paddr_o),
  .pready_i     (pready_i),
  .wbuf_valid   (wbuf_valid)
);

// File: tb/pbus_bridge_tb.sv
`timescale 1ns/1ps
module pbus_bridge_tb;
  localparam int AW = 12;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0;
  logic [1:0]    op = 2'b00;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          stall, rvalid, pce, psel, penable, pwrite, pready;
  logic [DW-1:0] rdata, pwdata, prdata;
  logic [AW-1:0] paddr;

  int tests = 0;
  int fails = 0;
  int cfg_wait = 0;
  int wait_left = 0;
  logic [DW-1:0] pmem [16];
  logic [DW-1:0] shadow [16];

  always #2 clk = ~clk;

  pbus_bridge #(.AW(AW), .DW(DW), .DIV(4)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cpu_req_i(req), .cpu_op_i(op),
    .cpu_addr_i(addr), .cpu_wdata_i(wdata), .cpu_stall_o(stall),
    .cpu_rvalid_o(rvalid), .cpu_rdata_o(rdata), .pclk_en_o(pce),
    .psel_o(psel), .penable_o(penable), .pwrite_o(pwrite), .paddr_o(paddr),
    .pwdata_o(pwdata), .prdata_i(prdata), .pready_i(pready)
  );

  // peripheral model
  assign pready = (wait_left == 0);
  assign prdata = pmem[paddr[3:0]];
  always @(posedge clk) begin
    if (pce && psel && !penable) wait_left <= cfg_wait;
    else if (pce && psel && penable) begin
      if (wait_left > 0) wait_left <= wait_left - 1;
      else if (pwrite) pmem[paddr[3:0]] <= pwdata;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // issue op at next negedge; count strobes in cycles before acceptance
  task automatic run_op(input logic [1:0] o, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        output int strobes, output int cycles,
                        output logic [DW-1:0] rd, output logic rv);
    @(negedge clk);
    req = 1'b1; op = o; addr = a; wdata = d;
    strobes = 0; cycles = 0;
    forever begin
      #1;
      if (!stall) begin
        rv = rvalid; rd = rdata;
        break;
      end
      if (pce) strobes++;
      cycles++;
      if (cycles > 2000) begin
        check(1'b0, "R4 stall timeout", cycles, 0);
        rv = 1'b0; rd = '0;
        break;
      end
      @(negedge clk);
    end
    if (o == 2'b01) shadow[a[3:0]] = d;
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    req = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #400000;
    check(1'b0, "watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int s, c;
    logic [DW-1:0] rd;
    logic rv;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 16; i++) begin pmem[i] = '0; shadow[i] = '0; end

    repeat (3) @(negedge clk);
    #1;
    check(!stall && !rvalid && !psel, "R9 reset outputs", {stall, rvalid, psel}, 0);
    rst_n = 1'b1;

    // R1 strobe spacing
    begin
      int last = -1, gap_bad = 0, seen = 0;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk); #1;
        if (pce) begin
          if (last >= 0 && (k - last) != 4) gap_bad++;
          last = k; seen++;
        end
      end
      check(gap_bad == 0 && seen == 10, "R1 strobe period", gap_bad, 0);
    end

    // R9/R2 first store after reset accepted at once
    run_op(2'b01, 12'h003, 32'hA5A5_0003, s, c, rd, rv);
    check(c == 0, "R2 R9 store accepted first cycle", c, 0);
    // R3 second store back-to-back
    run_op(2'b01, 12'h004, 32'h1111_0004, s, c, rd, rv);
    check(s == 3, "R3 second store waits 3 strobes", s, 3);
    // R6 barrier behind buffered write
    run_op(2'b10, 12'h000, 32'h0, s, c, rd, rv);
    check(s == 3, "R6 barrier waits for drain", s, 3);
    // R6 barrier with empty buffer
    run_op(2'b10, 12'h000, 32'h0, s, c, rd, rv);
    check(c == 0, "R6 barrier empty no stall", c, 0);
    idle(2);

    // R4 load on idle bus
    run_op(2'b00, 12'h003, 32'h0, s, c, rd, rv);
    check(s == 3, "R4 load strobes", s, 3);
    check(rv == 1'b1, "R4 rvalid at release", rv, 1);
    check(rd == 32'hA5A5_0003, "R4 load data", rd, 32'hA5A5_0003);
    @(negedge clk); req = 1'b0; #1;
    check(!rvalid, "R4 rvalid single cycle", rvalid, 0);
    check(!stall, "R7 no request no stall", stall, 0);

    // R7 buffer busy, no request
    run_op(2'b01, 12'h007, 32'hBEEF_0007, s, c, rd, rv);
    begin
      int st = 0;
      @(negedge clk); req = 1'b0;
      for (int k = 0; k < 6; k++) begin #1; if (stall) st++; @(negedge clk); end
      check(st == 0 && psel, "R7 stall low while write drains", st, 0);
    end
    idle(12);

    // R5 load behind buffered write
    run_op(2'b01, 12'h009, 32'hCAFE_0009, s, c, rd, rv);
    run_op(2'b00, 12'h009, 32'h0, s, c, rd, rv);
    check(s == 6, "R5 load after write strobes", s, 6);
    check(rd == 32'hCAFE_0009, "R5 load sees buffered write", rd, 32'hCAFE_0009);
    idle(2);

    // R10 wait states
    for (int w = 1; w <= 3; w++) begin
      cfg_wait = w;
      run_op(2'b00, 12'h004, 32'h0, s, c, rd, rv);
      check(s == 3 + w, "R10 load with wait states", s, 3 + w);
      check(rd == 32'h1111_0004, "R10 data with wait states", rd, 32'h1111_0004);
      idle(1);
    end

    // R8 setup then access observed at ports
    begin
      int setup_strobes = 0; bit addr_ok = 1; bit done = 0;
      cfg_wait = 1;
      @(negedge clk); req = 1'b1; op = 2'b00; addr = 12'h007;
      while (!done) begin
        #1;
        if (psel && !penable && pce) setup_strobes++;
        if (psel && paddr != 12'h007) addr_ok = 0;
        if (!stall) done = 1;
        @(negedge clk);
      end
      req = 1'b0;
      check(setup_strobes == 1 && addr_ok, "R8 single setup strobe, stable addr", setup_strobes, 1);
      cfg_wait = 0;
      idle(2);
    end

    // random traffic
    for (int n = 0; n < 300; n++) begin
      int r;
      logic [AW-1:0] a;
      cfg_wait = $urandom_range(0, 2);
      r = $urandom_range(0, 9);
      a = AW'($urandom_range(0, 15));
      if (r < 4) begin
        run_op(2'b01, a, $urandom, s, c, rd, rv);
      end else if (r < 8) begin
        run_op(2'b00, a, 32'h0, s, c, rd, rv);
        check(rv && rd == shadow[a[3:0]], "R5 random load order", rd, shadow[a[3:0]]);
      end else if (r == 8) begin
        run_op(2'b10, a, 32'h0, s, c, rd, rv);
      end else begin
        idle($urandom_range(0, 5));
      end
    end
    run_op(2'b10, 12'h0, 32'h0, s, c, rd, rv);
    idle(4);
    begin
      int bad = 0;
      for (int i = 0; i < 16; i++) if (pmem[i] !== shadow[i]) bad++;
      check(bad == 0, "R3 all stores reach peripheral", bad, 0);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule